// File: doc/BRIEF.md
# Multi-Mode Serial Receive Engine

This block turns a serial bit stream into parallel characters. It supports four framings, chosen by a two-bit mode input. Mode 0 is plain asynchronous: 8 data bits with no parity, or 7 data bits followed by an even or odd parity bit. Mode 1 is asynchronous multiprocessor, where an address/data marker follows the eighth data bit. Mode 2 is clocked synchronous, with an optional stop bit. Mode 3 is the asynchronous 8-bit framing used on a single-wire automotive bus. In the asynchronous modes, `sample_en` is a 16x oversampling tick. In mode 2 it marks one serial-clock sampling instant per bit.

When a character completes, the engine does four things at once. It loads the holding register, sets the ready flag, updates the parity, overrun and framing error flags, and raises an interrupt request if that is enabled. A read strobe consumes the ready flag. A separate clear strobe drops the error flags. When any error flag is set, the held character must be treated as invalid.

Top module: `sio_rx_engine`

## Requirements
- R1: In modes 0 and 3, a start bit, 8 data bits sent LSB first and a high stop bit are delivered on `rdata`, and `rdy` goes to 1 on the clock edge that takes the stop-bit sample.
- R2: In mode 0 with `len7`=1 and `par_en`=1, 7 data bits appear on `rdata[6:0]` with `rdata[7]`=0, and the parity bit sits in the eighth bit position. The parity is even when `par_odd`=0 and odd when it is 1. A mismatch sets `perr`.
- R3: `perr` never becomes 1 for a character received in mode 1 or mode 3, whatever `par_en` is.
- R4: In mode 1, the bit after the eighth data bit is presented on `addr_flag` together with the character.
- R5: In mode 2 with `stop_sel`=0, the character is stored on the edge that samples the eighth data bit. With `stop_sel`=1, it is stored on the edge that samples a ninth, stop, bit.
- R6: A stop bit sampled low sets `ferr`.
- R7: If a character completes while `rdy` is 1 and no read occurs in that cycle, `oerr` is set and `rdata` keeps the earlier character.
- R8: `rd_strobe` clears `rdy`. A read in the same cycle as a completion is taken before it, so the new character is stored with no overrun.
- R9: `err_clr` clears `perr`, `oerr` and `ferr` unless a new error is set in that same cycle.
- R10: `irq` is 1 exactly while `rie`=1 and at least one of `rdy`, `perr`, `oerr`, `ferr` is 1. All flags are 0 after reset.
- R11: In the asynchronous modes, a low level seen on a tick while idle is sampled again 8 ticks later. If the line is high by then, the receiver returns to idle and produces no character.
- R12: After a qualified start, each following bit is sampled once every 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | 16x tick (async modes) or bit sample strobe (mode 2) |
| rxd | input | 1 | Serial data in |
| mode | input | 2 | 0 async, 1 multiprocessor, 2 synchronous, 3 bus async |
| len7 | input | 1 | Mode 0: 7 data bits |
| par_en | input | 1 | Mode 0: parity bit present |
| par_odd | input | 1 | Mode 0: odd parity |
| stop_sel | input | 1 | Mode 2: stop bit present |
| rie | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Data register read, clears ready |
| err_clr | input | 1 | Clears error flags |
| rdata | output | 8 | Received character |
| addr_flag | output | 1 | Mode 1 address/data bit of the held character |
| rdy | output | 1 | Character ready |
| perr | output | 1 | Parity error |
| oerr | output | 1 | Overrun error |
| ferr | output | 1 | Framing error |
| irq | output | 1 | Receive interrupt request |

## Verification
A bit-index counter left in the wrong state shifts every field of the character. It corrupts `rdata` or `addr_flag` on the very next completion, and it moves the cycle in which `rdy` rises, which the mode 2 timing check sees to within one clock. An oversampling phase that is off gives a bad character or a framing error within one frame. A ready flag that is stuck shows up as a wrong `oerr` or a missing `irq` change within a few cycles after the next read.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

  typedef enum logic [1:0] {
    RXM_ASYNC  = 2'd0,
    RXM_MPROC  = 2'd1,
    RXM_SYNC   = 2'd2,
    RXM_LINBUS = 2'd3
  } rx_mode_e;

  // number of data bits in the current framing
  function automatic int unsigned data_bits(rx_mode_e m, logic len7, int unsigned w);
    return (m == RXM_ASYNC && len7) ? w - 1 : w;
  endfunction

  // one extra bit after the data: parity (mode 0) or address marker (mode 1)
  function automatic int unsigned extra_bits(rx_mode_e m, logic par_en);
    return (m == RXM_MPROC || (m == RXM_ASYNC && par_en)) ? 1 : 0;
  endfunction

  function automatic int unsigned stop_bits(rx_mode_e m, logic stop_sel);
    return (m != RXM_SYNC || stop_sel) ? 1 : 0;
  endfunction

  // 1 when data plus parity bit disagree with the selected sense
  function automatic logic parity_bad(logic [31:0] d, logic pbit, logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction

endpackage

// File: rtl/sio_rx_bitclk.sv
module sio_rx_bitclk #(
  parameter int OS_RATE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic rxd,
  input  logic sync_mode,
  input  logic frame_end,
  output logic bit_pick,
  output logic false_start
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OS_RATE - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OS_RATE / 2 - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_RUN} st_e;
  st_e st;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    bit_pick    = sync_mode ? sample_en : (st == ST_RUN && sample_en && cnt == LAST);
    false_start = !sync_mode && st == ST_START && sample_en && cnt == MID && rxd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (sync_mode) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (sample_en) begin
      case (st)
        ST_IDLE: if (!rxd) begin
          st  <= ST_START;
          cnt <= '0;
        end
        ST_START: if (cnt == MID) begin
          cnt <= '0;
          st  <= rxd ? ST_IDLE : ST_RUN;
        end else cnt <= cnt + 1'b1;
        ST_RUN: if (cnt == LAST) begin
          cnt <= '0;
          if (frame_end) st <= ST_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // entering the data phase needs a low mid-start sample
  AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && $past(st) == ST_START) |-> !$past(rxd)); // R11

endmodule

// File: rtl/sio_rx_framer.sv
module sio_rx_framer
  import sio_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_pick,
  input  logic              rxd,
  input  rx_mode_e          m,
  input  logic              len7,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop_sel,
  output logic              commit,
  output logic [DATA_W-1:0] data,
  output logic              ad,
  output logic              perr,
  output logic              ferr
);
  localparam int IDX_W = $clog2(DATA_W + 3);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sh, data_nx;
  logic              xbit, xbit_nx;
  int unsigned       idx_i, nd, nx, ns, last;

  always_comb begin
    idx_i = 32'(idx);
    nd    = data_bits(m, len7, DATA_W);
    nx    = extra_bits(m, par_en);
    ns    = stop_bits(m, stop_sel);
    last  = nd + nx + ns - 1;
    for (int i = 0; i < DATA_W; i++) begin
      data_nx[i] = (bit_pick && idx_i == 32'(i)) ? rxd : sh[i];
      data[i]    = (32'(i) < nd) ? data_nx[i] : 1'b0;
    end
    xbit_nx = (bit_pick && idx_i == nd) ? rxd : xbit;
    commit  = bit_pick && idx_i >= last;
    ad      = (m == RXM_MPROC) && xbit_nx;
    perr    = (m == RXM_ASYNC) && par_en && parity_bad(32'(data), xbit_nx, par_odd);
    ferr    = commit && (ns != 0) && !rxd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      sh   <= '0;
      xbit <= 1'b0;
    end else if (bit_pick) begin
      sh   <= data_nx;
      xbit <= xbit_nx;
      idx  <= commit ? '0 : idx + 1'b1;
    end
  end

endmodule

// File: rtl/sio_rx_flags.sv
module sio_rx_flags
  import sio_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rx_mode_e          m,
  input  logic              commit,
  input  logic [DATA_W-1:0] data,
  input  logic              ad,
  input  logic              perr_in,
  input  logic              ferr_in,
  input  logic              rd_strobe,
  input  logic              err_clr,
  input  logic              rie,
  output logic [DATA_W-1:0] rdata,
  output logic              addr_flag,
  output logic              rdy,
  output logic              perr,
  output logic              oerr,
  output logic              ferr,
  output logic              irq
);
  logic held, ovr_ev, load_ev;

  always_comb begin
    held    = rdy && !rd_strobe;
    ovr_ev  = commit && held;
    load_ev = commit && !held;
    irq     = rie && (rdy || perr || oerr || ferr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      addr_flag <= 1'b0;
      rdy       <= 1'b0;
      perr      <= 1'b0;
      oerr      <= 1'b0;
      ferr      <= 1'b0;
    end else begin
      if (load_ev) begin
        rdata     <= data;
        addr_flag <= ad;
      end
      rdy  <= load_ev || held;
      perr <= (perr && !err_clr) || (load_ev && perr_in);
      ferr <= (ferr && !err_clr) || (load_ev && ferr_in);
      oerr <= (oerr && !err_clr) || ovr_ev;
    end
  end

  AST_PE_ONLY_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr) |-> $past(m) == RXM_ASYNC); // R3
  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rdy && !rd_strobe) |=> (oerr && rdy && $stable(rdata))); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !commit) |=> !rdy); // R8
  AST_CLEAR_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !commit) |=> (!perr && !oerr && !ferr)); // R9
  AST_IRQ_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rdy) && rie) |-> irq); // R10

endmodule

// File: rtl/sio_rx_engine.sv
module sio_rx_engine
  import sio_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              rxd,
  input  logic [1:0]        mode,
  input  logic              len7,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop_sel,
  input  logic              rie,
  input  logic              rd_strobe,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rdata,
  output logic              addr_flag,
  output logic              rdy,
  output logic              perr,
  output logic              oerr,
  output logic              ferr,
  output logic              irq
);
  rx_mode_e          m;
  logic              bit_pick, false_start, commit, f_ad, f_perr, f_ferr;
  logic [DATA_W-1:0] f_data;

  assign m = rx_mode_e'(mode);

  sio_rx_bitclk #(.OS_RATE(OS_RATE)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd),
    .sync_mode(m == RXM_SYNC), .frame_end(commit),
    .bit_pick(bit_pick), .false_start(false_start)
  );

  sio_rx_framer #(.DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .bit_pick(bit_pick), .rxd(rxd), .m(m),
    .len7(len7), .par_en(par_en), .par_odd(par_odd), .stop_sel(stop_sel),
    .commit(commit), .data(f_data), .ad(f_ad), .perr(f_perr), .ferr(f_ferr)
  );

  sio_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .m(m), .commit(commit), .data(f_data),
    .ad(f_ad), .perr_in(f_perr), .ferr_in(f_ferr), .rd_strobe(rd_strobe),
    .err_clr(err_clr), .rie(rie), .rdata(rdata), .addr_flag(addr_flag),
    .rdy(rdy), .perr(perr), .oerr(oerr), .ferr(ferr), .irq(irq)
  );

  // a rejected start never completes a character on the same tick
  AST_NO_COMMIT_ON_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |-> !commit); // R11

endmodule

// File: tb/sio_rx_engine_tb_top.sv
module sio_rx_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sample_en = 1'b1, rxd = 1'b1;
  logic [1:0] mode = 2'd0;
  logic len7 = 0, par_en = 0, par_odd = 0, stop_sel = 0, rie = 1;
  logic mon_rd = 0, mon_clr = 0, main_rd = 0;
  logic rd_strobe, err_clr;
  logic [7:0] rdata;
  logic addr_flag, rdy, perr, oerr, ferr, irq;

  assign rd_strobe = mon_rd | main_rd;
  assign err_clr   = mon_clr;

  always #2 clk = ~clk;

  sio_rx_engine dut_i (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd), .mode(mode),
    .len7(len7), .par_en(par_en), .par_odd(par_odd), .stop_sel(stop_sel),
    .rie(rie), .rd_strobe(rd_strobe), .err_clr(err_clr), .rdata(rdata),
    .addr_flag(addr_flag), .rdy(rdy), .perr(perr), .oerr(oerr), .ferr(ferr),
    .irq(irq)
  );

  typedef struct packed { logic [7:0] d; logic ad; logic pe; logic fe; } exp_t;
  exp_t q[$];
  int nvec = 0, nbad = 0;
  bit auto_rd = 1, done = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic ad, input logic pe, input logic fe);
    exp_t e;
    e.d = d; e.ad = ad; e.pe = pe; e.fe = fe;
    q.push_back(e);
  endtask

  // monitor: pops expected characters as rdy appears, then reads and clears
  initial begin
    forever begin
      @(negedge clk);
      if (auto_rd && rdy) begin
        if (q.size() == 0) chk(0, "R11 unexpected character", rdata, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(rdata == e.d, "R1/R2/R4/R5 data", rdata, e.d);
          chk(addr_flag == e.ad, "R4 addr_flag", addr_flag, e.ad);
          chk(perr == e.pe, "R2/R3 perr", perr, e.pe);
          chk(ferr == e.fe, "R6 ferr", ferr, e.fe);
        end
        mon_rd = 1; mon_clr = 1;
        @(negedge clk);
        mon_rd = 0; mon_clr = 0;
      end
    end
  end

  task automatic send_async(input logic [8:0] pay, input int n, input logic stopv, input int stoplen);
    rxd = 0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = pay[i];
      repeat (16) @(negedge clk);
    end
    rxd = stopv;
    repeat (stoplen) @(negedge clk);
    rxd = 1;
    repeat (48) @(negedge clk);
  endtask

  task automatic send_sync(input logic [7:0] d, input bit with_stop, input logic stopv,
                           input bit do_rd, output logic pre, output logic post);
    sample_en = 1;
    pre = 0;
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      if (i == 7 && !with_stop) begin pre = rdy; main_rd = do_rd; end
      @(negedge clk);
      main_rd = 0;
    end
    if (with_stop) begin rxd = stopv; pre = rdy; @(negedge clk); end
    post = rdy;
    sample_en = 0;
    rxd = 1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic pre, post;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R10)
    chk(!rdy && !perr && !oerr && !ferr, "R10 reset flags", {rdy, perr, oerr, ferr}, 0);
    chk(!irq, "R10 reset irq", irq, 0);

    // R10: irq follows ready, drops after read
    auto_rd = 0;
    push(8'hA5, 0, 0, 0);
    send_async({1'b0, 8'hA5}, 8, 1, 16);
    chk(rdy == 1, "R1 rdy", rdy, 1);
    chk(irq == 1, "R10 irq set", irq, 1);
    auto_rd = 1;
    repeat (4) @(negedge clk);
    chk(irq == 0, "R10 irq clear", irq, 0);

    // R1 R12: 8N1 mode 0
    push(8'h3C, 0, 0, 0);
    send_async({1'b0, 8'h3C}, 8, 1, 16);
    push(8'hFF, 0, 0, 0);
    send_async({1'b0, 8'hFF}, 8, 1, 16);

    // R2: 7 data bits with parity
    len7 = 1; par_en = 1; par_odd = 0;
    push(8'h55, 0, 0, 0);
    send_async({1'b0, ^7'h55, 7'h55}, 8, 1, 16);
    push(8'h07, 0, 1, 0);
    send_async({1'b0, ~^7'h07, 7'h07}, 8, 1, 16);
    par_odd = 1;
    push(8'h01, 0, 0, 0);
    send_async({1'b0, ~^7'h01, 7'h01}, 8, 1, 16);
    len7 = 0;
    push(8'h81, 0, 0, 0);
    send_async({~^8'h81, 8'h81}, 9, 1, 16);

    // R6 and R11: low stop bit; the remaining short low is a false start
    par_en = 0;
    push(8'h96, 0, 0, 1);
    send_async({1'b0, 8'h96}, 8, 0, 10);

    // R11: short glitch while idle
    auto_rd = 0;
    rxd = 0; repeat (5) @(negedge clk);
    rxd = 1; repeat (40) @(negedge clk);
    chk(rdy == 0, "R11 false start", rdy, 0);
    auto_rd = 1;

    // R3 R4: mode 1 address marker, parity config ignored
    mode = 2'd1; par_en = 1;
    push(8'h81, 1, 0, 0);
    send_async({1'b1, 8'h81}, 9, 1, 16);
    push(8'h42, 0, 0, 0);
    send_async({1'b0, 8'h42}, 9, 1, 16);
    // R3: mode 3
    mode = 2'd3;
    push(8'h07, 0, 0, 0);
    send_async({1'b0, 8'h07}, 8, 1, 16);
    par_en = 0;

    // R7: overrun keeps first character
    mode = 2'd0;
    auto_rd = 0;
    push(8'h11, 0, 0, 0);
    send_async({1'b0, 8'h11}, 8, 1, 16);
    send_async({1'b0, 8'h22}, 8, 1, 16);
    chk(oerr == 1, "R7 oerr", oerr, 1);
    chk(rdata == 8'h11, "R7 data kept", rdata, 8'h11);
    auto_rd = 1;
    repeat (4) @(negedge clk);
    chk(oerr == 0, "R9 err_clr", oerr, 0);
    chk(irq == 0, "R10 irq idle", irq, 0);

    // R5: synchronous mode without stop bit
    sample_en = 0;
    @(negedge clk);
    mode = 2'd2; stop_sel = 0;
    auto_rd = 0;
    send_sync(8'h5A, 0, 1, 0, pre, post);
    chk(pre == 0 && post == 1, "R5 store at last data bit", {pre, post}, 2'b01);
    chk(rdata == 8'h5A, "R5 sync data", rdata, 8'h5A);
    // R8: read in the completion cycle
    push(8'hC3, 0, 0, 0);
    send_sync(8'hC3, 0, 1, 1, pre, post);
    chk(rdy == 1 && oerr == 0, "R8 read before completion", {rdy, oerr}, 2'b10);
    chk(rdata == 8'hC3, "R8 new data", rdata, 8'hC3);
    auto_rd = 1;
    repeat (4) @(negedge clk);
    // R5 R6: with stop bit
    stop_sel = 1;
    auto_rd = 0;
    send_sync(8'h3E, 1, 0, 0, pre, post);
    chk(pre == 0 && post == 1, "R5 store at stop bit", {pre, post}, 2'b01);
    push(8'h3E, 0, 0, 1);
    auto_rd = 1;
    repeat (4) @(negedge clk);

    chk(q.size() == 0, "R1 all characters seen", q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule